// File: doc/BRIEF.md
# 16-bit Multiply-Accumulate Unit

This execution unit sits beside the integer pipeline of a 32-bit core. Each issued operation takes two 32-bit source values, keeps only the low 16 bits of each, and multiplies them as unsigned or as two's-complement numbers, depending on a mode bit. The 32-bit product is widened to 40 bits and added to a 40-bit accumulator. The sum is written back to the accumulator, and its low 32 bits go to the destination register of the operation.

The accumulator is stored in two 32-bit registers. The low register holds sum bits [31:0]. The high register holds sum bits [39:32] in its bits [7:0], and multiply-accumulate operations never change its bits [31:8]. A separate access port lets the core read and write either register as a special register. The unit accepts a new operation every clock and has no back-pressure. Because of this, the issue port has a valid bit but no ready bit, and the unit never refuses an operation. The writeback appears two clocks after issue. A combinational stall request tells the pipeline when the instruction following an operation reads that operation's destination.

Top module: `mac16_unit`

## Requirements
- R1: Only bits [15:0] of `in_a` and `in_b` enter the multiplier. Bits [31:16] have no effect on the result.
- R2: With `in_signed`=0, both 16-bit operands are unsigned. The product is zero-extended to 40 bits before the add.
- R3: With `in_signed`=1, both 16-bit operands are two's-complement. The product is sign-extended to 40 bits before the add.
- R4: The sum is accumulator + extended product, taken modulo 2^40. Sum bits [31:0] go to the low register and sum bits [39:32] go to bits [7:0] of the high register. No overflow indication exists.
- R5: An operation issued in cycle t gives `wb_valid`=1 in cycle t+2, with `wb_dst` equal to its `in_dst` and `wb_data` equal to sum[31:0]. In every other cycle `wb_valid` is 0.
- R6: Operations may issue on consecutive clocks. Each one accumulates onto the value left by the one before it, with no stall.
- R7: In cycle t+1 after an issue in cycle t, `stall_req` is 1 exactly when `nxt_valid`=1 and `nxt_rs1` or `nxt_rs2` equals that operation's `in_dst`. Otherwise `stall_req` is 0.
- R8: `sr_rd_data` shows the low register when `sr_rd_sel`=0 and the high register when it is 1. A write with `sr_wr_en`=1 loads `sr_wr_data` into the register chosen by `sr_wr_sel` at the next edge, using the same encoding.
- R9: A multiply-accumulate update leaves bits [31:8] of the high register unchanged.
- R10: If a special-register write meets an accumulate update at the same edge, the write is dropped and the accumulate result is kept.
- R11: A synchronous `rst` clears both accumulator registers, the in-flight operation and `wb_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Issue an operation this cycle |
| in_signed | input | 1 | 1 = signed mode, 0 = unsigned mode |
| in_a | input | 32 | First source value |
| in_b | input | 32 | Second source value |
| in_dst | input | 5 | Destination register index |
| nxt_valid | input | 1 | The following instruction is present |
| nxt_rs1 | input | 5 | First source index of the following instruction |
| nxt_rs2 | input | 5 | Second source index of the following instruction |
| stall_req | output | 1 | Hold the following instruction one cycle |
| wb_valid | output | 1 | Writeback present |
| wb_dst | output | 5 | Writeback register index |
| wb_data | output | 32 | Writeback value, sum[31:0] |
| sr_wr_en | input | 1 | Special-register write strobe |
| sr_wr_sel | input | 1 | Write target: 0 low, 1 high |
| sr_wr_data | input | 32 | Special-register write value |
| sr_rd_sel | input | 1 | Read source: 0 low, 1 high |
| sr_rd_data | output | 32 | Special-register read value |

## Verification
The hardest case to reach from the ports is a special-register write that lands on the same edge as an accumulate commit. It only happens when the write is driven exactly one cycle after an issue. The bench issues an operation, drives a low-register write in the very next cycle, and reads the register back once the pipeline has drained. The same one-cycle offset is used to present a dependent following instruction for the stall check. Carry into bit 39 and the wrap past 2^40 are reached by preloading the accumulator through the access port.

// File: rtl/mac16_pkg.sv
package mac16_pkg;
  localparam int MAC_XLEN = 32;
  localparam int MAC_OPW  = 16;
  localparam int MAC_ACCW = 40;
  localparam int MAC_RIDX = 5;

  typedef enum logic {
    SR_LOW  = 1'b0,
    SR_HIGH = 1'b1
  } sr_sel_e;
endpackage

// File: rtl/mac16_mult.sv
module mac16_mult #(
  parameter int OPW  = mac16_pkg::MAC_OPW,
  parameter int ACCW = mac16_pkg::MAC_ACCW
) (
  input  logic            sgn,
  input  logic [OPW-1:0]  a,
  input  logic [OPW-1:0]  b,
  output logic [ACCW-1:0] prod_ext
);
  localparam int PW = 2 * OPW;

  logic signed [OPW:0]    ax;
  logic signed [OPW:0]    bx;
  logic signed [PW+1:0]   pw;
  logic        [PW-1:0]   p;
  logic                   fill;

  // one guard bit per operand makes a single signed multiplier serve both modes
  assign ax   = {sgn & a[OPW-1], a};
  assign bx   = {sgn & b[OPW-1], b};
  assign pw   = ax * bx;
  assign p    = pw[PW-1:0];
  assign fill = sgn & p[PW-1];

  generate
    if (ACCW > PW) begin : g_widen
      assign prod_ext = {{(ACCW-PW){fill}}, p};
    end else begin : g_trunc
      logic unused_fill;
      assign unused_fill = fill;
      assign prod_ext = p[ACCW-1:0];
    end
  endgenerate
endmodule

// File: rtl/mac16_acc.sv
module mac16_acc #(
  parameter int XLEN = mac16_pkg::MAC_XLEN,
  parameter int ACCW = mac16_pkg::MAC_ACCW,
  parameter int RIDX = mac16_pkg::MAC_RIDX
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            commit,
  input  logic [ACCW-1:0] prod,
  input  logic [RIDX-1:0] dst,
  input  logic            sr_wr_en,
  input  logic            sr_wr_sel,
  input  logic [XLEN-1:0] sr_wr_data,
  output logic [XLEN-1:0] lo_q,
  output logic [XLEN-1:0] hi_q,
  output logic            wb_valid,
  output logic [RIDX-1:0] wb_dst,
  output logic [XLEN-1:0] wb_data
);
  import mac16_pkg::*;
  localparam int HIW = ACCW - XLEN;

  logic [ACCW-1:0] acc_now;
  logic [ACCW-1:0] sum;

  assign acc_now = {hi_q[HIW-1:0], lo_q};
  assign sum     = acc_now + prod;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (commit) begin
      lo_q <= sum[XLEN-1:0];
      hi_q <= {hi_q[XLEN-1:HIW], sum[ACCW-1:XLEN]};
    end else if (sr_wr_en) begin
      if (sr_sel_e'(sr_wr_sel) == SR_HIGH) hi_q <= sr_wr_data;
      else                                  lo_q <= sr_wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid <= 1'b0;
      wb_dst   <= '0;
      wb_data  <= '0;
    end else begin
      wb_valid <= commit;
      if (commit) begin
        wb_dst  <= dst;
        wb_data <= sum[XLEN-1:0];
      end
    end
  end
endmodule

// File: rtl/mac16_hazard.sv
module mac16_hazard #(
  parameter int RIDX = mac16_pkg::MAC_RIDX
) (
  input  logic            busy,
  input  logic [RIDX-1:0] busy_dst,
  input  logic            nxt_valid,
  input  logic [RIDX-1:0] nxt_rs1,
  input  logic [RIDX-1:0] nxt_rs2,
  output logic            stall_req
);
  logic hit1, hit2;
  assign hit1      = (nxt_rs1 == busy_dst);
  assign hit2      = (nxt_rs2 == busy_dst);
  assign stall_req = busy & nxt_valid & (hit1 | hit2);
endmodule

// File: rtl/mac16_unit.sv
module mac16_unit #(
  parameter int XLEN = mac16_pkg::MAC_XLEN,
  parameter int OPW  = mac16_pkg::MAC_OPW,
  parameter int ACCW = mac16_pkg::MAC_ACCW,
  parameter int RIDX = mac16_pkg::MAC_RIDX
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic            in_signed,
  input  logic [XLEN-1:0] in_a,
  input  logic [XLEN-1:0] in_b,
  input  logic [RIDX-1:0] in_dst,
  input  logic            nxt_valid,
  input  logic [RIDX-1:0] nxt_rs1,
  input  logic [RIDX-1:0] nxt_rs2,
  output logic            stall_req,
  output logic            wb_valid,
  output logic [RIDX-1:0] wb_dst,
  output logic [XLEN-1:0] wb_data,
  input  logic            sr_wr_en,
  input  logic            sr_wr_sel,
  input  logic [XLEN-1:0] sr_wr_data,
  input  logic            sr_rd_sel,
  output logic [XLEN-1:0] sr_rd_data
);
  logic [ACCW-1:0] prod_c;
  logic            s1_valid;
  logic [RIDX-1:0] s1_dst;
  logic [ACCW-1:0] s1_prod;
  logic [XLEN-1:0] lo_w, hi_w;
  logic            unused_upper;

  assign unused_upper = ^{in_a[XLEN-1:OPW], in_b[XLEN-1:OPW]};

  mac16_mult #(.OPW(OPW), .ACCW(ACCW)) u_mult (
    .sgn(in_signed), .a(in_a[OPW-1:0]), .b(in_b[OPW-1:0]), .prod_ext(prod_c)
  );

  // first stage: registered product
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_dst   <= '0;
      s1_prod  <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_dst  <= in_dst;
        s1_prod <= prod_c;
      end
    end
  end

  mac16_acc #(.XLEN(XLEN), .ACCW(ACCW), .RIDX(RIDX)) u_acc (
    .clk(clk), .rst(rst), .commit(s1_valid), .prod(s1_prod), .dst(s1_dst),
    .sr_wr_en(sr_wr_en), .sr_wr_sel(sr_wr_sel), .sr_wr_data(sr_wr_data),
    .lo_q(lo_w), .hi_q(hi_w),
    .wb_valid(wb_valid), .wb_dst(wb_dst), .wb_data(wb_data)
  );

  mac16_hazard #(.RIDX(RIDX)) u_haz (
    .busy(s1_valid), .busy_dst(s1_dst), .nxt_valid(nxt_valid),
    .nxt_rs1(nxt_rs1), .nxt_rs2(nxt_rs2), .stall_req(stall_req)
  );

  assign sr_rd_data = sr_rd_sel ? hi_w : lo_w;
endmodule

// File: rtl/mac16_chk.sv
module mac16_chk #(
  parameter int XLEN = 32,
  parameter int RIDX = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [RIDX-1:0] in_dst,
  input logic            nxt_valid,
  input logic            stall_req,
  input logic            wb_valid,
  input logic [RIDX-1:0] wb_dst,
  input logic [XLEN-1:0] wb_data,
  input logic            sr_wr_en,
  input logic            sr_wr_sel,
  input logic [XLEN-1:0] acc_lo,
  input logic [XLEN-1:0] acc_hi
);
  logic [1:0] since_q;
  always_ff @(posedge clk) begin
    if (rst) since_q <= '0;
    else if (since_q != 2'd3) since_q <= since_q + 2'd1;
  end

  AST_WB_TWO_CYCLES: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##1 (wb_valid && wb_dst == $past(in_dst, 2))); // R5

  AST_NO_SPURIOUS_WB: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> (since_q >= 2'd2) && $past(in_valid, 2)); // R5

  AST_STALL_NEEDS_ISSUE: assert property (@(posedge clk) disable iff (rst)
    stall_req |-> (since_q >= 2'd1) && $past(in_valid) && nxt_valid); // R7

  AST_HIGH_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
    ((since_q >= 2'd1) && !$past(sr_wr_en && sr_wr_sel))
      |-> acc_hi[XLEN-1:8] == $past(acc_hi[XLEN-1:8])); // R9

  AST_WB_MATCHES_LOW: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> wb_data == acc_lo); // R10
endmodule

bind mac16_unit mac16_chk #(.XLEN(XLEN), .RIDX(RIDX)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_dst(in_dst),
  .nxt_valid(nxt_valid), .stall_req(stall_req),
  .wb_valid(wb_valid), .wb_dst(wb_dst), .wb_data(wb_data),
  .sr_wr_en(sr_wr_en), .sr_wr_sel(sr_wr_sel),
  .acc_lo(u_acc.lo_q), .acc_hi(u_acc.hi_q)
);

// File: tb/mac16_unit_tb_top.sv
`timescale 1ns/1ps
module mac16_unit_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, in_valid, in_signed, nxt_valid, stall_req, wb_valid;
  logic sr_wr_en, sr_wr_sel, sr_rd_sel;
  logic [31:0] in_a, in_b, wb_data, sr_wr_data, sr_rd_data;
  logic [4:0] in_dst, nxt_rs1, nxt_rs2, wb_dst;

  mac16_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_signed(in_signed),
    .in_a(in_a), .in_b(in_b), .in_dst(in_dst), .nxt_valid(nxt_valid),
    .nxt_rs1(nxt_rs1), .nxt_rs2(nxt_rs2), .stall_req(stall_req),
    .wb_valid(wb_valid), .wb_dst(wb_dst), .wb_data(wb_data),
    .sr_wr_en(sr_wr_en), .sr_wr_sel(sr_wr_sel), .sr_wr_data(sr_wr_data),
    .sr_rd_sel(sr_rd_sel), .sr_rd_data(sr_rd_data)
  );

  int nvec = 0, nbad = 0;
  bit done = 0;
  logic [31:0] m_lo, m_hi;
  typedef struct { bit v; logic [4:0] d; logic [31:0] data; } pe_t;
  pe_t p1, p2;

  function automatic logic [39:0] mprod(bit s, logic [31:0] a, logic [31:0] b);
    logic signed [31:0] sp;
    logic [31:0] up;
    sp = $signed(a[15:0]) * $signed(b[15:0]);
    up = 32'(a[15:0]) * 32'(b[15:0]);
    return s ? {{8{sp[31]}}, sp} : {8'h00, up};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_pipe();
    p1 = '{v: 1'b0, d: 5'd0, data: 32'd0};
    p2 = p1;
  endtask

  task automatic step(bit v, bit s, logic [31:0] a, logic [31:0] b, logic [4:0] d,
                      bit nv, logic [4:0] r1, logic [4:0] r2,
                      bit sw, bit ssel, logic [31:0] sd, string req);
    pe_t cur;
    logic [39:0] sum;
    chk("R5 wb_valid", 64'(wb_valid), 64'(p2.v));
    if (p2.v) begin
      chk(req, 64'(wb_data), 64'(p2.data));
      chk("R5 wb_dst", 64'(wb_dst), 64'(p2.d));
    end
    in_valid = v; in_signed = s; in_a = a; in_b = b; in_dst = d;
    nxt_valid = nv; nxt_rs1 = r1; nxt_rs2 = r2;
    sr_wr_en = sw; sr_wr_sel = ssel; sr_wr_data = sd;
    #1;
    chk("R7 stall", 64'(stall_req), 64'(p1.v && nv && (r1 == p1.d || r2 == p1.d)));
    if (sw && !p1.v) begin
      if (ssel) m_hi = sd; else m_lo = sd;
    end
    cur = '{v: v, d: d, data: 32'd0};
    if (v) begin
      sum = {m_hi[7:0], m_lo} + mprod(s, a, b);
      m_lo = sum[31:0];
      m_hi = {m_hi[31:8], sum[39:32]};
      cur.data = sum[31:0];
    end
    p2 = p1; p1 = cur;
    @(negedge clk);
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R5"); endtask
  task automatic srw(bit sel, logic [31:0] val);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, sel, val, "R8");
  endtask
  task automatic mac(bit s, logic [31:0] a, logic [31:0] b, logic [4:0] d, string req);
    step(1, s, a, b, d, 0, 0, 0, 0, 0, 0, req);
  endtask

  task automatic rd(bit sel, logic [31:0] exp, string req);
    idle(); idle();
    sr_rd_sel = sel;
    #1;
    chk(req, 64'(sr_rd_data), 64'(exp));
  endtask

  task automatic do_reset(int n);
    rst = 1; in_valid = 0; nxt_valid = 0; sr_wr_en = 0;
    repeat (n) @(negedge clk);
    rst = 0;
    m_lo = 0; m_hi = 0;
    clear_pipe();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    logic [15:0] vals [8];
    logic [4:0] prev_d;
    vals = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFF, 16'h8000, 16'h8001, 16'hFFFF, 16'h00FF};
    in_a = 0; in_b = 0; in_dst = 0; in_signed = 0; nxt_rs1 = 0; nxt_rs2 = 0;
    sr_wr_sel = 0; sr_wr_data = 0; sr_rd_sel = 0;
    @(negedge clk);
    do_reset(4);
    // R11: state after reset
    chk("R11 wb_valid", 64'(wb_valid), 0);
    chk("R11 stall", 64'(stall_req), 0);
    rd(0, 0, "R11 low");
    rd(1, 0, "R11 high");

    // R8: access port round trip
    srw(0, 32'h1357_9BDF);
    srw(1, 32'h2468_ACE0);
    rd(0, 32'h1357_9BDF, "R8 low");
    rd(1, 32'h2468_ACE0, "R8 high");
    srw(0, 0); srw(1, 0);

    // R2/R3/R6/R7: back-to-back sweep with garbage in upper bits (R1)
    prev_d = 0;
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++) begin
          logic [4:0] d;
          d = 5'((i * 8 + j) & 31);
          step(1, s[0], {16'(i * 37 + s + 1), vals[i]}, {16'(j * 91 + 5), vals[j]}, d,
               1, (j % 2 == 0) ? prev_d : 5'(prev_d + 1), 5'(i + 3), 0, 0, 0,
               s ? "R3 signed sweep" : "R2 unsigned sweep");
          prev_d = d;
        end
    rd(0, m_lo, "R6 low after chain");
    rd(1, m_hi, "R4 high after chain");

    // R1: upper operand bits ignored
    srw(0, 0); srw(1, 0);
    mac(0, 32'hFFFF_0003, 32'h1234_0005, 5'd7, "R1 upper bits");
    rd(0, 32'd15, "R1 low");

    // R4: wrap at 2^40
    srw(0, 32'hFFFF_FFFF); srw(1, 32'h0000_00FF);
    mac(0, 32'd1, 32'd1, 5'd2, "R4 wrap data");
    rd(0, 32'd0, "R4 wrap low");
    rd(1, 32'd0, "R4 wrap high");
    // R4: carry into bit 32
    srw(0, 32'hFFFF_FFF0);
    mac(0, 32'h0000_0004, 32'h0000_0008, 5'd3, "R4 carry data");
    rd(1, 32'd1, "R4 carry high");

    // R3: negative product sign-extends into the high byte
    srw(0, 0); srw(1, 0);
    mac(1, 32'h0000_FFFF, 32'h0000_0001, 5'd4, "R3 minus one");
    rd(1, 32'h0000_00FF, "R3 high byte");
    // R2: same bit pattern unsigned stays positive
    srw(0, 0); srw(1, 0);
    mac(0, 32'h0000_FFFF, 32'h0000_0001, 5'd4, "R2 ffff");
    rd(1, 32'd0, "R2 high byte");

    // R9: upper bits of the high register survive accumulation
    srw(0, 32'hFFFF_FF00); srw(1, 32'hABCD_EF00);
    mac(0, 32'h0000_0100, 32'h0000_0100, 5'd9, "R9 data");
    mac(1, 32'h0000_8000, 32'h0000_7FFF, 5'd10, "R9 data");
    rd(1, m_hi, "R9 high");
    chk("R9 upper", 64'(sr_rd_data[31:8]), 64'(24'hABCDEF));

    // R10: write colliding with a commit is dropped
    srw(0, 32'h0000_0010); srw(1, 0);
    mac(0, 32'd3, 32'd5, 5'd11, "R10 data");
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 32'hDEAD_BEEF, "R10");
    rd(0, 32'h0000_001F, "R10 low kept");
    srw(1, 32'h0000_0055);
    mac(0, 32'd1, 32'd1, 5'd12, "R10 data");
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 32'h7777_7777, "R10");
    rd(1, 32'h0000_0055, "R10 high kept");

    // R7: exactly one stall cycle, on either source, only for a match
    mac(0, 1, 1, 5'd20, "R7 data");
    step(0, 0, 0, 0, 0, 1, 5'd1, 5'd20, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 1, 5'd20, 5'd20, 0, 0, 0, "R7");
    mac(0, 1, 1, 5'd21, "R7 data");
    step(0, 0, 0, 0, 0, 1, 5'd22, 5'd23, 0, 0, 0, "R7");
    mac(0, 1, 1, 5'd24, "R7 data");
    step(0, 0, 0, 0, 0, 0, 5'd24, 5'd24, 0, 0, 0, "R7");
    idle(); idle();

    // R11: reset with an operation in flight
    mac(0, 32'd9, 32'd9, 5'd5, "R11 data");
    do_reset(1);
    chk("R11 flush wb", 64'(wb_valid), 0);
    @(negedge clk);
    chk("R11 flush wb2", 64'(wb_valid), 0);
    rd(0, 0, "R11 low flush");
    rd(1, 0, "R11 high flush");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule